// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-wire serial debug link. It takes one register-level command at a time from a parallel interface and carries it out on the wire: it builds the request packet, hands the shared data line to the target and takes it back, captures the target's three-bit acknowledge, and then either shifts 32 data bits plus parity out or captures them in. A separate command sends a line reset pattern that returns the target's link logic to a known state. The wire clock comes from a programmable divider of the system clock. The host changes the data line only while the wire clock is low and samples target data on its rising edge.

A command is accepted in the cycle where `cmd_valid` is high and the engine is idle. `busy` stays high for the whole transaction. `done` pulses for one cycle at the end, and the response fields are then held until the next command is accepted. Retry after WAIT and any layering above single register accesses belong to the logic that drives this block.

The controller has these states. `ST_IDLE` waits for a command. `ST_LRST_HI` and `ST_LRST_LO` drive the reset pattern. `ST_REQ` sends the request. `ST_TRN_A` is the turnaround before the acknowledge. `ST_ACK` captures the acknowledge. `ST_TRN_B` is the turnaround back to the host. `ST_WDATA` sends write data. `ST_RDATA` captures read data. `ST_TRN_C` is the turnaround after a read. `ST_TAIL` drives the idle cycles.

The transitions are:
- IDLE to REQ on a transfer command, and IDLE to LRST_HI on a reset command.
- LRST_HI to LRST_LO, then LRST_LO to IDLE.
- REQ to TRN_A to ACK.
- ACK to RDATA on OK for a read, and ACK to TRN_B on OK for a write or on WAIT or FAULT.
- ACK to IDLE on any other acknowledge.
- TRN_B to WDATA on OK, and otherwise TRN_B to TAIL.
- WDATA to TAIL, and RDATA to TRN_C to TAIL.
- TAIL to IDLE.

Every move into TAIL goes straight to IDLE when the idle count is zero. Each state lasts a whole number of wire bit periods. Every transition takes place on a falling edge of the wire clock.

Top module: `swd_host_engine`

## Requirements
- R1: After reset `swclk` is 0, `swdio_oe` is 1, `swdio_out` is 0 and `busy` is 0. The wire clock stays low whenever the engine is idle.
- R2: The first eight wire bits of a transfer are driven by the host (oe=1) in this order: 1, port select (0 = debug port, 1 = access port), read flag (1 = read), `cmd_addr[0]`, `cmd_addr[1]`, parity, 0, 1.
- R3: The request parity bit is the XOR of port select, read flag and both address bits, so that those five bits together have even parity.
- R4: Wire bits 8 to 11 are not driven by the host (oe=0): one turnaround bit, then three acknowledge bits. The first received acknowledge bit goes into `rsp_ack[0]`.
- R5: A read that gets OK (`rsp_ack` = 3'b001) captures 32 data bits, least significant first, from wire bits 12 to 43, and the parity bit from wire bit 44, all undriven. One more undriven turnaround bit follows. `rsp_rdata` returns the data.
- R6: `rsp_parity_err` is 1 after a read that got OK only if the XOR of the 32 data bits and the received parity bit is 1. It is 0 after every other transaction.
- R7: A write that gets OK has one undriven turnaround bit (bit 12). Then the host drives 32 data bits, least significant first, followed by their even parity bit (bits 13 to 45).
- R8: WAIT (3'b010) and FAULT (3'b100) are reported in `rsp_ack`. They are followed by one undriven turnaround bit and then the idle tail, with no data phase.
- R9: Any other acknowledge value ends the transaction after bit 11 with `rsp_proto_err` = 1 and no idle tail. The line then stays released (oe=0) until the next command is accepted, and that command clears the flag.
- R10: Every completed transfer, except one ending in a protocol error, ends with `idle_cycles` host-driven low bits. A value of 0 adds no bits.
- R11: Each half period of `swclk` lasts `clk_half_div`+1 system clock cycles. `swdio_out` and `swdio_oe` change only while `swclk` is low.
- R12: A reset command drives 56 high bits and then 2 low bits (set by parameters, at least 50 and 2), and has no acknowledge or data phase.
- R13: A command presented while `busy` is 1 is ignored. `done` is a single-cycle pulse, and `busy` is 0 while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_half_div | input | DIV_W | Wire clock half period minus one, in system cycles; captured when a command is accepted |
| idle_cycles | input | IDLE_W | Number of low idle bits after a transfer; captured when a command is accepted |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_line_reset | input | 1 | 1 selects the line reset pattern instead of a transfer |
| cmd_ap_sel | input | 1 | 0 = debug port register, 1 = access port register |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register address bits 3:2 |
| cmd_wdata | input | 32 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rsp_ack | output | 3 | Received acknowledge, first wire bit in bit 0 |
| rsp_rdata | output | 32 | Read data |
| rsp_parity_err | output | 1 | Read data parity mismatch |
| rsp_proto_err | output | 1 | Acknowledge was none of OK, WAIT or FAULT |
| swclk | output | 1 | Wire clock |
| swdio_out | output | 1 | Data line value driven by the host |
| swdio_oe | output | 1 | Host drives the data line when 1 |
| swdio_in | input | 1 | Data line value as seen by the host |

## Verification
A wrong state or bit counter shows up on the wire within one bit period. A bit is added or dropped, or the output enable comes up in a target-owned slot, and so the number of rising clock edges in the transaction and the per-bit driven values no longer match the expected frame for that acknowledge. A wrong decision on the acknowledge shows at `done` as a transaction length of 12, 13+idle or 46+idle where another was due. A capture fault in the read shifter shows at `rsp_rdata` or `rsp_parity_err` in the cycle `done` pulses. The divider is checked by timing the distance between rising edges of `swclk`, so a one-count error appears on the second bit.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LRST_HI,
        ST_LRST_LO,
        ST_REQ,
        ST_TRN_A,
        ST_ACK,
        ST_TRN_B,
        ST_WDATA,
        ST_RDATA,
        ST_TRN_C,
        ST_TAIL
    } swd_state_e;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    localparam int REQ_BITS  = 8;
    localparam int ACK_BITS  = 3;
    localparam int DATA_BITS = 32;

    // Request packet, bit 0 is sent first.
    function automatic logic [REQ_BITS-1:0] build_request(
        input logic       port_sel,
        input logic       is_read,
        input logic [1:0] reg_addr
    );
        logic par;
        par = port_sel ^ is_read ^ reg_addr[0] ^ reg_addr[1];
        return {1'b1, 1'b0, par, reg_addr[1], reg_addr[0], is_read, port_sel, 1'b1};
    endfunction

endpackage

// File: rtl/swd_clk_gen.sv
module swd_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick     = en && (cnt == half_div);
    assign rise_stb = tick && !sclk;
    assign fall_stb = tick && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/swd_req_framer.sv
module swd_req_framer
    import swd_host_pkg::*;
(
    input  logic                port_sel,
    input  logic                is_read,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_BITS-1:0] wdata,
    output logic [REQ_BITS-1:0] req_pkt,
    output logic [DATA_BITS:0]  wr_frame
);
    always_comb begin
        req_pkt  = build_request(port_sel, is_read, reg_addr);
        wr_frame = {^wdata, wdata};
    end
endmodule

// File: rtl/swd_rx_shift.sv
module swd_rx_shift #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    generate
        if (W == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        q <= '0;
                else if (clr)      q <= '0;
                else if (shift_en) q <= bit_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        q <= '0;
                else if (clr)      q <= '0;
                else if (shift_en) q <= {bit_in, q[W-1:1]};
            end
        end
    endgenerate
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
    import swd_host_pkg::*;
#(
    parameter int DIV_W         = 8,
    parameter int IDLE_W        = 8,
    parameter int RST_HIGH_BITS = 56,
    parameter int RST_LOW_BITS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_half_div,
    input  logic [IDLE_W-1:0] idle_cycles,
    input  logic              cmd_valid,
    input  logic              cmd_line_reset,
    input  logic              cmd_ap_sel,
    input  logic              cmd_read,
    input  logic [1:0]        cmd_addr,
    input  logic [31:0]       cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [2:0]        rsp_ack,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_parity_err,
    output logic              rsp_proto_err,
    output logic              swclk,
    output logic              swdio_out,
    output logic              swdio_oe,
    input  logic              swdio_in
);
    localparam int CW_RST = $clog2(RST_HIGH_BITS + 1);
    localparam int CW_MIN = (IDLE_W > 6) ? IDLE_W : 6;
    localparam int CNT_W  = (CW_RST > CW_MIN) ? CW_RST : CW_MIN;
    localparam int FRM_W  = DATA_BITS + 1;

    swd_state_e state, state_n;

    logic [CNT_W-1:0]    bit_cnt, bit_limit;
    logic                last_bit, adv, accept;
    logic                rise_stb, fall_stb;
    logic [DIV_W-1:0]    div_q;
    logic [IDLE_W-1:0]   idle_q;
    logic                rnw_q, released;
    logic [REQ_BITS-1:0] req_sr, req_pkt;
    logic [FRM_W-1:0]    wd_sr, wr_frame;
    logic [ACK_BITS-1:0] ack_word;
    logic [FRM_W-1:0]    rd_word;
    logic                ack_known;
    swd_state_e          after_xfer;

    assign accept    = (state == ST_IDLE) && cmd_valid;
    assign busy      = (state != ST_IDLE);
    assign ack_known = (ack_word == ACK_OK) || (ack_word == ACK_WAIT) || (ack_word == ACK_FAULT);
    assign after_xfer = (idle_q == '0) ? ST_IDLE : ST_TAIL;

    swd_clk_gen #(.DIV_W(DIV_W)) i_clk_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (busy),
        .half_div (div_q),
        .sclk     (swclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    swd_req_framer i_framer (
        .port_sel (cmd_ap_sel),
        .is_read  (cmd_read),
        .reg_addr (cmd_addr),
        .wdata    (cmd_wdata),
        .req_pkt  (req_pkt),
        .wr_frame (wr_frame)
    );

    swd_rx_shift #(.W(ACK_BITS)) i_ack_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .shift_en (rise_stb && (state == ST_ACK)),
        .bit_in   (swdio_in),
        .q        (ack_word)
    );

    swd_rx_shift #(.W(FRM_W)) i_data_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .shift_en (rise_stb && (state == ST_RDATA)),
        .bit_in   (swdio_in),
        .q        (rd_word)
    );

    // Number of wire bits each state lasts
    always_comb begin
        unique case (state)
            ST_LRST_HI:          bit_limit = CNT_W'(RST_HIGH_BITS);
            ST_LRST_LO:          bit_limit = CNT_W'(RST_LOW_BITS);
            ST_REQ:              bit_limit = CNT_W'(REQ_BITS);
            ST_ACK:              bit_limit = CNT_W'(ACK_BITS);
            ST_WDATA, ST_RDATA:  bit_limit = CNT_W'(FRM_W);
            ST_TAIL:             bit_limit = CNT_W'(idle_q);
            default:             bit_limit = CNT_W'(1);
        endcase
    end

    assign last_bit = (bit_cnt == bit_limit - CNT_W'(1));
    assign adv      = fall_stb && last_bit;

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (cmd_valid) state_n = cmd_line_reset ? ST_LRST_HI : ST_REQ;
            ST_LRST_HI: if (adv) state_n = ST_LRST_LO;
            ST_LRST_LO: if (adv) state_n = ST_IDLE;
            ST_REQ:     if (adv) state_n = ST_TRN_A;
            ST_TRN_A:   if (adv) state_n = ST_ACK;
            ST_ACK: begin
                if (adv) begin
                    if (!ack_known)                        state_n = ST_IDLE;
                    else if ((ack_word == ACK_OK) && rnw_q) state_n = ST_RDATA;
                    else                                   state_n = ST_TRN_B;
                end
            end
            ST_TRN_B:   if (adv) state_n = (ack_word == ACK_OK) ? ST_WDATA : after_xfer;
            ST_WDATA:   if (adv) state_n = after_xfer;
            ST_RDATA:   if (adv) state_n = ST_TRN_C;
            ST_TRN_C:   if (adv) state_n = after_xfer;
            ST_TAIL:    if (adv) state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Bit counter within a state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 bit_cnt <= '0;
        else if (state_n != state)  bit_cnt <= '0;
        else if (fall_stb)          bit_cnt <= bit_cnt + CNT_W'(1);
    end

    // Command capture, transmit shifting and responses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q          <= '0;
            idle_q         <= '0;
            rnw_q          <= 1'b0;
            released       <= 1'b0;
            req_sr         <= '0;
            wd_sr          <= '0;
            done           <= 1'b0;
            rsp_ack        <= '0;
            rsp_rdata      <= '0;
            rsp_parity_err <= 1'b0;
            rsp_proto_err  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                div_q          <= clk_half_div;
                idle_q         <= idle_cycles;
                rnw_q          <= cmd_read;
                released       <= 1'b0;
                req_sr         <= req_pkt;
                wd_sr          <= wr_frame;
                rsp_ack        <= '0;
                rsp_parity_err <= 1'b0;
                rsp_proto_err  <= 1'b0;
            end else begin
                if (fall_stb && (state == ST_REQ))
                    req_sr <= {1'b0, req_sr[REQ_BITS-1:1]};
                if (fall_stb && (state == ST_WDATA))
                    wd_sr <= {1'b0, wd_sr[FRM_W-1:1]};
                if (adv && (state == ST_ACK)) begin
                    rsp_ack <= ack_word;
                    if (!ack_known) begin
                        rsp_proto_err <= 1'b1;
                        released      <= 1'b1;
                    end
                end
                if (adv && (state == ST_RDATA)) begin
                    rsp_rdata      <= rd_word[DATA_BITS-1:0];
                    rsp_parity_err <= ^rd_word;
                end
                if ((state != ST_IDLE) && (state_n == ST_IDLE))
                    done <= 1'b1;
            end
        end
    end

    // Line outputs
    always_comb begin
        swdio_oe  = 1'b1;
        swdio_out = 1'b0;
        unique case (state)
            ST_IDLE:    swdio_oe  = ~released;
            ST_LRST_HI: swdio_out = 1'b1;
            ST_LRST_LO: swdio_out = 1'b0;
            ST_REQ:     swdio_out = req_sr[0];
            ST_WDATA:   swdio_out = wd_sr[0];
            ST_TAIL:    swdio_out = 1'b0;
            default:    swdio_oe  = 1'b0;
        endcase
    end
endmodule

// File: rtl/swd_host_checker.sv
module swd_host_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       swclk,
    input logic       swdio_out,
    input logic       swdio_oe,
    input logic       busy,
    input logic       done,
    input logic [2:0] rsp_ack,
    input logic       rsp_parity_err,
    input logic       rsp_proto_err
);
    AST_LINE_MOVES_ON_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(swdio_out) || !$stable(swdio_oe)) |-> !swclk); // R11

    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !swclk); // R1

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R13

    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R13

    AST_PROTO_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_proto_err && !busy) |-> !swdio_oe); // R9

    AST_PARITY_ERR_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_parity_err |-> (rsp_ack == 3'b001)); // R6
endmodule

bind swd_host_engine swd_host_checker i_swd_host_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .swclk          (swclk),
    .swdio_out      (swdio_out),
    .swdio_oe       (swdio_oe),
    .busy           (busy),
    .done           (done),
    .rsp_ack        (rsp_ack),
    .rsp_parity_err (rsp_parity_err),
    .rsp_proto_err  (rsp_proto_err)
);

// File: tb/test_swd_host_engine.sv
module test_swd_host_engine;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PERIOD = 10;
    localparam int MAXB       = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  clk_half_div = 8'd1;
    logic [7:0]  idle_cycles = 8'd0;
    logic        cmd_valid = 1'b0;
    logic        cmd_line_reset = 1'b0;
    logic        cmd_ap_sel = 1'b0;
    logic        cmd_read = 1'b0;
    logic [1:0]  cmd_addr = 2'd0;
    logic [31:0] cmd_wdata = '0;
    logic        busy, done;
    logic [2:0]  rsp_ack;
    logic [31:0] rsp_rdata;
    logic        rsp_parity_err, rsp_proto_err;
    logic        swclk, swdio_out, swdio_oe;
    logic        swdio_in = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    swd_host_engine i_swd_host_engine (
        .clk(clk), .rst_n(rst_n), .clk_half_div(clk_half_div), .idle_cycles(idle_cycles),
        .cmd_valid(cmd_valid), .cmd_line_reset(cmd_line_reset), .cmd_ap_sel(cmd_ap_sel),
        .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
        .rsp_parity_err(rsp_parity_err), .rsp_proto_err(rsp_proto_err),
        .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Target model
    logic [2:0]  tgt_ack = 3'b001;
    logic [31:0] tgt_rdata = '0;
    logic        tgt_bad_par = 1'b0;
    logic        tgt_read = 1'b0;

    int   rise_cnt = 0;
    int   done_cnt = 0;
    logic host_oe [MAXB];
    logic host_out[MAXB];
    time  rise_t  [MAXB];
    logic exp_oe  [MAXB];
    logic exp_out [MAXB];
    int   exp_len;

    function automatic logic tgt_bit(input int n);
        if (n >= 9 && n <= 11) return tgt_ack[n-9];
        if (tgt_read && tgt_ack == 3'b001 && n >= 12 && n <= 43) return tgt_rdata[n-12];
        if (tgt_read && tgt_ack == 3'b001 && n == 44) return (^tgt_rdata) ^ tgt_bad_par;
        return 1'b1;
    endfunction

    always @(posedge swclk) begin
        if (rise_cnt < MAXB) begin
            host_oe[rise_cnt]  = swdio_oe;
            host_out[rise_cnt] = swdio_out;
            rise_t[rise_cnt]   = $time;
        end
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge swclk) swdio_in = tgt_bit(rise_cnt);

    always @(negedge clk) if (rst_n && done) done_cnt = done_cnt + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic oe, input logic v);
        if (exp_len < MAXB) begin
            exp_oe[exp_len]  = oe;
            exp_out[exp_len] = v;
        end
        exp_len++;
    endtask

    task automatic build_expect(input logic ap, input logic rd, input logic [1:0] a,
                                input logic [31:0] wd, input logic [2:0] ack, input int idle);
        exp_len = 0;
        push(1, 1); push(1, ap); push(1, rd); push(1, a[0]); push(1, a[1]);
        push(1, ap ^ rd ^ a[0] ^ a[1]); push(1, 0); push(1, 1);
        for (int i = 0; i < 4; i++) push(0, 0);
        if (ack == 3'b001 || ack == 3'b010 || ack == 3'b100) begin
            if (ack == 3'b001 && rd) begin
                for (int i = 0; i < 34; i++) push(0, 0);
            end else begin
                push(0, 0);
                if (ack == 3'b001) begin
                    for (int i = 0; i < 32; i++) push(1, wd[i]);
                    push(1, ^wd);
                end
            end
            for (int i = 0; i < idle; i++) push(1, 0);
        end
    endtask

    task automatic compare_range(input int lo, input int hi, input string tag, input string what);
        int bad;
        bad = -1;
        for (int k = lo; k < hi && k < MAXB; k++) begin
            if (bad < 0 && (host_oe[k] !== exp_oe[k] || (exp_oe[k] && host_out[k] !== exp_out[k])))
                bad = k;
        end
        if (bad >= 0)
            check(0, tag, $sformatf("%s bit %0d oe/out", what, bad),
                  {62'd0, host_oe[bad], host_out[bad]}, {62'd0, exp_oe[bad], exp_out[bad]});
        else
            check(1, tag, what, 0, 0);
    endtask

    task automatic compare_frame(input string tag);
        check(rise_cnt == exp_len, tag, "wire bit count", rise_cnt, exp_len);
        compare_range(0, 8, "R2/R3", "request bits");
        compare_range(8, (exp_len < 12) ? exp_len : 12, "R4", "turnaround and ack ownership");
        compare_range(12, exp_len, tag, "data and tail bits");
    endtask

    task automatic wait_done();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic run_txn(input logic ap, input logic rd, input logic [1:0] a,
                           input logic [31:0] wd, input logic [2:0] ack,
                           input logic [31:0] rdat, input logic badp,
                           input int idle, input int div, input bit poke, input string tag);
        tgt_ack = ack; tgt_rdata = rdat; tgt_bad_par = badp; tgt_read = rd;
        build_expect(ap, rd, a, wd, ack, idle);
        @(negedge clk);
        rise_cnt = 0; done_cnt = 0;
        clk_half_div = div[7:0]; idle_cycles = idle[7:0];
        cmd_ap_sel = ap; cmd_read = rd; cmd_addr = a; cmd_wdata = wd;
        cmd_line_reset = 1'b0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            cmd_line_reset = 1'b1; cmd_read = ~rd; cmd_ap_sel = ~ap;
            cmd_wdata = 32'hFFFF_FFFF; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0; cmd_line_reset = 1'b0;
        end
        wait_done();
        compare_frame(tag);
    endtask

    // Scenarios
    task automatic t_reset_state();
        @(negedge clk);
        check(swclk == 1'b0, "R1", "swclk after reset", swclk, 0);
        check(swdio_oe == 1'b1 && swdio_out == 1'b0, "R1", "line after reset",
              {swdio_oe, swdio_out}, 2'b10);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    endtask

    task automatic t_read_ok();
        run_txn(0, 1, 2'd0, 0, 3'b001, 32'h2BA0_1477, 0, 2, 1, 0, "R5 R10");
        check(rsp_ack == 3'b001, "R5", "read ack", rsp_ack, 3'b001);
        check(rsp_rdata == 32'h2BA0_1477, "R5", "read data", rsp_rdata, 32'h2BA0_1477);
        check(rsp_parity_err == 1'b0, "R6", "good parity flag", rsp_parity_err, 0);
        check(busy == 1'b0, "R13", "busy at done", busy, 0);
    endtask

    task automatic t_read_bad_parity();
        run_txn(1, 1, 2'd3, 0, 3'b001, 32'hA5A5_0F0E, 1, 1, 2, 0, "R6");
        check(rsp_parity_err == 1'b1, "R6", "bad parity flag", rsp_parity_err, 1);
        check(rsp_rdata == 32'hA5A5_0F0E, "R6", "data with bad parity", rsp_rdata, 32'hA5A5_0F0E);
    endtask

    task automatic t_write_ok_fast();
        run_txn(1, 0, 2'd2, 32'h8000_0001, 3'b001, 0, 0, 0, 0, 0, "R7 R10");
        check(rsp_ack == 3'b001 && rsp_parity_err == 1'b0, "R7", "write ack/perr",
              {rsp_ack, rsp_parity_err}, 4'b0010);
        check(rise_t[2] - rise_t[1] == 2 * CLK_PERIOD, "R11", "period div=0",
              rise_t[2] - rise_t[1], 2 * CLK_PERIOD);
    endtask

    task automatic t_wait_read();
        run_txn(0, 1, 2'd1, 0, 3'b010, 32'hDEAD_BEEF, 0, 3, 1, 0, "R8 R10");
        check(rsp_ack == 3'b010, "R8", "wait ack", rsp_ack, 3'b010);
        check(rsp_parity_err == 1'b0, "R6", "no parity flag on wait", rsp_parity_err, 0);
    endtask

    task automatic t_fault_write();
        run_txn(1, 0, 2'd1, 32'h1234_5678, 3'b100, 0, 0, 1, 1, 0, "R8");
        check(rsp_ack == 3'b100, "R8", "fault ack", rsp_ack, 3'b100);
    endtask

    task automatic t_proto_err();
        run_txn(0, 1, 2'd2, 0, 3'b111, 32'h0, 0, 4, 1, 0, "R9");
        check(rsp_proto_err == 1'b1, "R9", "protocol error flag", rsp_proto_err, 1);
        repeat (20) @(negedge clk);
        check(swdio_oe == 1'b0, "R9", "line released after error", swdio_oe, 0);
    endtask

    task automatic t_busy_ignore();
        run_txn(1, 1, 2'd1, 0, 3'b001, 32'h0F1E_2D3C, 0, 1, 1, 1, "R13");
        check(rsp_proto_err == 1'b0, "R9", "error cleared by next command", rsp_proto_err, 0);
        check(rsp_rdata == 32'h0F1E_2D3C, "R13", "read unaffected by ignored cmd",
              rsp_rdata, 32'h0F1E_2D3C);
        repeat (200) @(negedge clk);
        check(done_cnt == 1, "R13", "single done", done_cnt, 1);
        check(busy == 1'b0 && rise_cnt == exp_len, "R13", "no extra transaction",
              rise_cnt, exp_len);
    endtask

    task automatic t_divider();
        run_txn(0, 0, 2'd3, 32'h5555_AAAA, 3'b001, 0, 0, 2, 3, 0, "R7");
        check(rise_t[2] - rise_t[1] == 8 * CLK_PERIOD, "R11", "period div=3",
              rise_t[2] - rise_t[1], 8 * CLK_PERIOD);
    endtask

    task automatic t_line_reset();
        exp_len = 0;
        for (int i = 0; i < 56; i++) push(1, 1);
        push(1, 0); push(1, 0);
        @(negedge clk);
        rise_cnt = 0; clk_half_div = 8'd0;
        cmd_line_reset = 1'b1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_line_reset = 1'b0;
        wait_done();
        check(rise_cnt == exp_len, "R12", "reset bit count", rise_cnt, exp_len);
        compare_range(0, exp_len, "R12", "reset pattern");
        check(rsp_ack == 3'b000, "R12", "no ack on reset", rsp_ack, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_read_ok();
        t_read_bad_parity();
        t_write_ok_fast();
        t_wait_read();
        t_fault_write();
        t_proto_err();
        t_busy_ignore();
        t_divider();
        t_line_reset();
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule